// File: doc/BRIEF.md
# Row-Column 2-D DCT Sequencer

This block computes the two-dimensional discrete cosine transform of an 8x8 tile of unsigned 8-bit pixels. It splits the work into two one-dimensional passes. Each pixel row that arrives with its valid strobe goes through an eight-point cosine stage at once. The sixteen-bit result is written into one half of a two-bank transpose store. When eight rows have filled a bank, the block reads that bank one column per clock. It sends each column through a second eight-point stage that applies the final scale and rounding, and drives the result out as a coefficient vector with its own valid strobe.

The index-zero weight of 1/√2 is folded into both passes, and the overall factor of 1/4 is folded into the final right shift. The two banks let the next tile stream in while the previous tile is being read out. At full input rate, output follows input with no gaps. The final beat of each tile raises a one-cycle done flag.

Top module: `dct2d_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `coef_valid_o` and `block_done_o` are 0 and `coef_o` is all zeros.
- R2: Call the rows of a tile y = 0..7 in arrival order, and call the pixel in lane x of a row `row_pix_i[8x+7:8x]`. Output beat j (j = 0..7) of that tile carries, in lane v (`coef_o[13v+12:13v]`, two's complement), F(v,j) = ¼·w(v)·w(j)·Σ p(y,x)·cos((2y+1)vπ/16)·cos((2x+1)jπ/16), rounded to the nearest integer within ±1. Here w(0) = 1/√2 and w(k) = 1 for k > 0.
- R3: Extreme tiles are transformed without overflow of the 16-bit intermediate or the 13-bit output: all 255 gives a DC of 2040, and a 0/255 checkerboard gives the correct result.
- R4: Column output starts only after the eighth row of a tile is sampled. If the reader is idle, beat 0 is valid on the second rising edge after the edge that sampled the eighth row. The eight beats of a tile come on eight consecutive edges, and `coef_valid_o` is low on every other edge.
- R5: `block_done_o` is high for exactly one cycle per tile, together with beat 7, and never without `coef_valid_o`.
- R6: Rows of the next tile are accepted while the previous tile is read out. Tiles sent back to back at one row per clock produce back-to-back output with no gaps, and each tile keeps its own result.
- R7: Cycles with `row_valid_i` low have no effect: neither the value on `row_pix_i` in those cycles nor the gap length changes any coefficient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_valid_i | input | 1 | A pixel row is present on `row_pix_i` this cycle |
| row_pix_i | input | 64 | Eight unsigned 8-bit pixels, lane x in bits 8x+7:8x |
| coef_valid_o | output | 1 | `coef_o` carries one output beat |
| coef_o | output | 104 | Eight signed 13-bit coefficients, lane v in bits 13v+12:13v |
| block_done_o | output | 1 | One-cycle pulse with the last beat of a tile |

## Verification
The hardest case to reach is a bank swap where the reader clears a bank's full flag on the same edge that the writer fills the other bank. The writer then comes back to the first bank on the very next row. This only happens when tiles arrive at one row per clock with no gaps. The stimulus therefore streams several pseudo-random tiles back to back after the extreme-value tiles. A cycle-exact model predicts the edge of every beat, so one extra or missing cycle at a swap is reported. Tiles with gaps carry random values on the pixel lanes during the idle cycles, to show that only strobed rows are used.

// File: rtl/dct2d_pkg.sv
package dct2d_pkg;

    localparam int LANES    = 8;
    localparam int COS_FRAC = 12;

    // Cosine weight in Q12 for frequency freq at sample position pos,
    // with the 1/sqrt(2) weight folded in for frequency zero.
    function automatic int cos_q12(input int freq, input int pos);
        int ang;
        int mag;
        bit neg;
        ang = ((2 * pos + 1) * freq) % 32;
        neg = 1'b0;
        if (ang > 16) ang = 32 - ang;
        if (ang > 8) begin
            ang = 16 - ang;
            neg = 1'b1;
        end
        case (ang)
            0: mag = 4096;
            1: mag = 4017;
            2: mag = 3784;
            3: mag = 3406;
            4: mag = 2896;
            5: mag = 2276;
            6: mag = 1567;
            7: mag = 799;
            default: mag = 0;
        endcase
        if (freq == 0) mag = 2896;
        return neg ? -mag : mag;
    endfunction

endpackage

// File: rtl/dct8_stage.sv
module dct8_stage
    import dct2d_pkg::*;
#(
    parameter int IN_W      = 8,
    parameter bit IN_SIGNED = 1'b0,
    parameter int OUT_W     = 16,
    parameter int SHIFT     = 8
) (
    input  logic [LANES*IN_W-1:0]  vec_i,
    output logic [LANES*OUT_W-1:0] vec_o
);

    localparam int ACC_W = IN_W + 20;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (SHIFT - 1));
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] MINV = ACC_W'(-(64'sd1 <<< (OUT_W - 1)));

    logic signed [ACC_W-1:0] samp [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_ext
        if (IN_SIGNED) begin : g_sx
            assign samp[i] = {{(ACC_W-IN_W){vec_i[i*IN_W+IN_W-1]}}, vec_i[i*IN_W +: IN_W]};
        end else begin : g_zx
            assign samp[i] = {{(ACC_W-IN_W){1'b0}}, vec_i[i*IN_W +: IN_W]};
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_freq
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] rnd;

        always_comb begin
            acc = '0;
            for (int p = 0; p < LANES; p++) begin
                acc = acc + samp[p] * ACC_W'(cos_q12(k, p));
            end
            rnd = (acc + HALF) >>> SHIFT;
        end

        always_comb begin
            assert_fits_width_R3: assert (rnd <= MAXV && rnd >= MINV)
                else $error("stage result exceeds %0d bits", OUT_W);
        end

        assign vec_o[k*OUT_W +: OUT_W] = rnd[OUT_W-1:0];
    end

endmodule

// File: rtl/dct_transpose_store.sv
module dct_transpose_store
    import dct2d_pkg::*;
#(
    parameter int MID_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [LANES*MID_W-1:0] wr_row_i,
    output logic                   col_valid_o,
    output logic                   col_last_o,
    output logic [LANES*MID_W-1:0] col_data_o
);

    localparam int IDX_W = $clog2(LANES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

    typedef struct packed {
        logic [1:0][LANES-1:0][LANES-1:0][MID_W-1:0] mem;
        logic [1:0]       full;
        logic             wr_bank;
        logic [IDX_W-1:0] wr_row;
        logic             rd_bank;
        logic [IDX_W-1:0] rd_col;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // write side: one row per strobe into the filling bank
        if (wr_en_i) begin
            st_d.mem[st_q.wr_bank][st_q.wr_row] = wr_row_i;
            st_d.wr_row = st_q.wr_row + 1'b1;
            if (st_q.wr_row == LAST_IDX) begin
                st_d.full[st_q.wr_bank] = 1'b1;
                st_d.wr_bank = ~st_q.wr_bank;
            end
        end
        // read side: one column per cycle from a full bank
        if (st_q.full[st_q.rd_bank]) begin
            st_d.rd_col = st_q.rd_col + 1'b1;
            if (st_q.rd_col == LAST_IDX) begin
                st_d.full[st_q.rd_bank] = 1'b0;
                st_d.rd_bank = ~st_q.rd_bank;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int r = 0; r < LANES; r++) begin
            col_data_o[r*MID_W +: MID_W] = st_q.mem[st_q.rd_bank][r][st_q.rd_col];
        end
    end

    assign col_valid_o = st_q.full[st_q.rd_bank];
    assign col_last_o  = (st_q.rd_col == LAST_IDX);

    assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> !st_q.full[st_q.wr_bank]);

    assert_read_from_filled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && st_q.rd_col != '0) |-> $past(col_valid_o));

endmodule

// File: rtl/dct2d_seq.sv
module dct2d_seq
    import dct2d_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int MID_W     = 16,
    parameter int COEF_W    = 13,
    parameter int ROW_SHIFT = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    row_valid_i,
    input  logic [LANES*PIX_W-1:0]  row_pix_i,
    output logic                    coef_valid_o,
    output logic [LANES*COEF_W-1:0] coef_o,
    output logic                    block_done_o
);

    // Q12 x Q12 products, minus the row shift, plus 2 bits for the 1/4 scale
    localparam int COL_SHIFT = 2 * COS_FRAC + 2 - ROW_SHIFT;

    typedef struct packed {
        logic                    valid;
        logic                    done;
        logic [LANES*COEF_W-1:0] coef;
    } out_t;

    out_t st_d, st_q;

    logic [LANES*MID_W-1:0]  row_res;
    logic [LANES*MID_W-1:0]  col_data;
    logic [LANES*COEF_W-1:0] col_res;
    logic                    col_valid;
    logic                    col_last;

    dct8_stage #(
        .IN_W(PIX_W), .IN_SIGNED(1'b0), .OUT_W(MID_W), .SHIFT(ROW_SHIFT)
    ) u_row (
        .vec_i(row_pix_i),
        .vec_o(row_res)
    );

    dct_transpose_store #(.MID_W(MID_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (row_valid_i),
        .wr_row_i   (row_res),
        .col_valid_o(col_valid),
        .col_last_o (col_last),
        .col_data_o (col_data)
    );

    dct8_stage #(
        .IN_W(MID_W), .IN_SIGNED(1'b1), .OUT_W(COEF_W), .SHIFT(COL_SHIFT)
    ) u_col (
        .vec_i(col_data),
        .vec_o(col_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = col_valid;
        st_d.done  = col_valid && col_last;
        if (col_valid) st_d.coef = col_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign coef_valid_o = st_q.valid;
    assign block_done_o = st_q.done;
    assign coef_o       = st_q.coef;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!coef_valid_o && !block_done_o && coef_o == '0));

    assert_done_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        block_done_o |-> coef_valid_o);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        block_done_o |=> !block_done_o);

endmodule

// File: tb/sim_dct2d_seq.sv
`timescale 1ns/1ps
module sim_dct2d_seq;

    localparam int PW = 8;
    localparam int CW = 13;
    localparam real PI = 3.14159265358979323846;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            row_valid = 1'b0;
    logic [8*PW-1:0] row_pix = '0;
    logic            coef_valid;
    logic [8*CW-1:0] coef;
    logic            block_done;

    dct2d_seq u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_valid_i (row_valid),
        .row_pix_i   (row_pix),
        .coef_valid_o(coef_valid),
        .coef_o      (coef),
        .block_done_o(block_done)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit started = 1'b0;
    bit finished = 1'b0;
    int unsigned seed = 32'h1234_5678;

    int blk [64];
    int nrows = 0;
    int last_end = 0;
    int    exp_cyc [$];
    int    exp_val [$];
    bit    exp_last[$];
    string exp_tag [$];

    function automatic real wgt(input int k);
        return (k == 0) ? 1.0 / $sqrt(2.0) : 1.0;
    endfunction

    function automatic int next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[23:16]);
    endfunction

    // Reference: tile complete at edge c; reader starts after it is free.
    task automatic close_tile(input int c, input string tag);
        int start;
        real s;
        start = ((c > last_end) ? c : last_end) + 1;
        for (int j = 0; j < 8; j++) begin
            exp_cyc.push_back(start + j);
            exp_last.push_back(j == 7);
            exp_tag.push_back(tag);
            for (int v = 0; v < 8; v++) begin
                s = 0.0;
                for (int y = 0; y < 8; y++)
                    for (int x = 0; x < 8; x++)
                        s += real'(blk[y*8+x]) * $cos((2*y+1)*v*PI/16.0)
                                               * $cos((2*x+1)*j*PI/16.0);
                s = s * 0.25 * wgt(v) * wgt(j);
                exp_val.push_back($rtoi($floor(s + 0.5)));
            end
        end
        last_end = start + 7;
    endtask

    task automatic send_row(input logic [63:0] pix, input int gap, input string tag);
        @(negedge clk);
        row_valid = 1'b1;
        row_pix   = pix;
        for (int x = 0; x < 8; x++) blk[nrows*8+x] = int'(pix[x*8 +: 8]);
        nrows++;
        if (nrows == 8) begin
            close_tile(cyc + 1, tag);
            nrows = 0;
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            row_valid = 1'b0;
            for (int x = 0; x < 8; x++) row_pix[x*8 +: 8] = 8'(next_rand());
        end
    endtask

    // kind: 0 ramp, 1 all 255, 2 checkerboard, 3 zero, 4 random, 5 stripes
    task automatic send_tile(input int kind, input int gap, input string tag);
        logic [63:0] pix;
        int p;
        for (int r = 0; r < 8; r++) begin
            for (int x = 0; x < 8; x++) begin
                case (kind)
                    0: p = (r * 8 + x) * 4;
                    1: p = 255;
                    2: p = ((r + x) % 2 == 1) ? 255 : 0;
                    3: p = 0;
                    5: p = (x % 2 == 0) ? 200 + r : 17;
                    default: p = next_rand();
                endcase
                pix[x*8 +: 8] = 8'(p);
            end
            send_row(pix, gap, tag);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            row_valid = 1'b0;
        end
    endtask

    // cycle-by-cycle comparison against the reference queues
    always @(negedge clk) begin
        if (started && !finished) begin
            if (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
                n_chk++; n_bad++;
                $display("FAIL R4 beat missing: actual none at edge %0d, expected edge %0d",
                         cyc, exp_cyc[0]);
                void'(exp_cyc.pop_front()); void'(exp_last.pop_front());
                void'(exp_tag.pop_front());
                for (int v = 0; v < 8; v++) void'(exp_val.pop_front());
            end
            if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
                int act;
                bit bad;
                n_chk++;
                if (!coef_valid) begin
                    n_bad++;
                    $display("FAIL R4 valid at edge %0d: actual 0 expected 1", cyc);
                end
                n_chk++;
                bad = 1'b0;
                for (int v = 0; v < 8; v++) begin
                    act = int'($signed(coef[v*CW +: CW]));
                    if (act > exp_val[v] + 1 || act < exp_val[v] - 1) begin
                        if (!bad) n_bad++;
                        bad = 1'b1;
                        $display("FAIL R2 (%s) lane %0d edge %0d: actual %0d expected %0d",
                                 exp_tag[0], v, cyc, act, exp_val[v]);
                    end
                end
                n_chk++;
                if (block_done != exp_last[0]) begin
                    n_bad++;
                    $display("FAIL R5 done at edge %0d: actual %0b expected %0b",
                             cyc, block_done, exp_last[0]);
                end
                void'(exp_cyc.pop_front()); void'(exp_last.pop_front());
                void'(exp_tag.pop_front());
                for (int v = 0; v < 8; v++) void'(exp_val.pop_front());
            end else if (coef_valid || block_done) begin
                n_chk++; n_bad++;
                $display("FAIL R4 unexpected output at edge %0d: actual valid=%0b done=%0b expected 0",
                         cyc, coef_valid, block_done);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        n_chk++;
        if (coef_valid || block_done || coef != '0) begin
            n_bad++;
            $display("FAIL R1 in reset: actual valid=%0b done=%0b coef=%h expected 0",
                     coef_valid, block_done, coef);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first cycle after release
        n_chk++;
        if (coef_valid || block_done || coef != '0) begin
            n_bad++;
            $display("FAIL R1 after release: actual valid=%0b done=%0b coef=%h expected 0",
                     coef_valid, block_done, coef);
        end
        started = 1'b1;

        send_tile(0, 0, "R2 ramp");
        idle(12);
        send_tile(1, 0, "R3 all-255");
        send_tile(2, 0, "R3 checker");
        send_tile(3, 0, "R2 zero");
        idle(12);
        for (int b = 0; b < 4; b++) send_tile(4, 0, "R6 back-to-back");
        send_tile(5, 1, "R7 gap1");
        send_tile(4, 3, "R7 gap3");
        idle(4);
        while (exp_cyc.size() > 0) @(negedge clk);
        repeat (6) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        finished = 1'b1;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d beats pending, expected 0", exp_cyc.size());
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule